// File: doc/BRIEF.md
# SPI-Refreshed Supervisor Watchdog

This block supervises a microcontroller on behalf of a system basis chip. Software proves it is alive by writing SPI control words in which a single refresh bit changes state. A decoded write strobe hands the block the refresh bit and the frame's mode-selection field while chip select is low. The frame is only acted upon when chip select returns high. All timing is counted in millisecond ticks supplied from outside.

Two supervision styles exist. In time-out mode a refresh may come at any moment before the period runs out. In window mode the period is cut into a closed first half and an open second half, and the refresh must fall into the open half. A missed deadline or an early refresh pulls the active-low reset output low. A policy input then chooses between two outcomes. In the restart outcome the reset is a fixed-length pulse, after which supervision resumes with a 256 ms time-out setting. In the fail-safe outcome the reset is held until the block itself is reset. The failure cause is kept in sticky status bits.

Top module: `wdg_supervisor`

## Requirements
- R1: A committed frame refreshes the watchdog only when its refresh bit differs from the stored refresh bit; either direction of change counts, and a frame that repeats the stored value changes nothing.
- R2: A frame takes effect only on the clock after chip select rises; while chip select stays low the timer keeps running and can expire.
- R3: Only mode-selection codes 0 to 3 (3-bit field) allow a refresh; a frame with code 4 to 7 neither refreshes nor updates the stored refresh bit.
- R4: The period in ticks is 16 × 2^code for codes 0 to 6; code 7 gives 1024.
- R5: In time-out mode the failure occurs on the period-th tick after the last refresh (or after reset or restart), and any valid refresh before that restarts the count.
- R6: In window mode a valid refresh arriving after fewer than half the period's ticks is an early failure; one arriving after half the period or more restarts the count.
- R7: After reset the active setting is time-out mode with code 4 (256 ticks); each valid refresh loads the mode and period code present on the configuration inputs.
- R8: On a failure under the restart policy (policy input 0) the reset output goes low on the next clock edge, the restart request is high while reset is low, the pulse lasts 8 ticks, and the timer then resumes from zero with the 256-tick time-out setting.
- R9: Under the fail-safe policy (policy input 1) a failure holds the reset output low and the fail-safe request high until the block's own reset; refreshes have no effect in that state.
- R10: The time-out and early-failure status bits are set by their cause and stay set until the block's reset.
- R11: Out of reset the reset output is high and both requests and both status bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| spi_wr_stb | input | 1 | Decoded control-word write strobe, valid while chip select is low |
| spi_refresh_bit | input | 1 | Refresh bit of the written word |
| spi_mode_sel | input | 3 | Mode-selection field of the written word |
| spi_cs_n | input | 1 | SPI chip select, active low |
| cfg_period_code | input | 3 | Period code loaded on a valid refresh |
| cfg_window_mode | input | 1 | 1 selects window mode, 0 time-out mode, loaded on a valid refresh |
| cfg_fail_safe | input | 1 | Failure policy: 1 fail-safe, 0 restart |
| wd_reset_n | output | 1 | Active-low reset to the microcontroller |
| req_restart | output | 1 | Restart request, high during the reset pulse |
| req_failsafe | output | 1 | Fail-safe request, held until block reset |
| stat_timeout | output | 1 | Sticky: a period expired without refresh |
| stat_early | output | 1 | Sticky: a refresh hit the closed window |

## Verification
The hardest situation to reach from the ports is the fallback after a restart: the block has just left its reset pulse with window settings still on the configuration inputs, and it must judge the next refresh by the 256-tick time-out rule while loading the window rule for the period after. The bench drives ticks and frames as discrete, non-overlapping steps, so it reaches that point by letting a window period expire, counting out the pulse, refreshing ten ticks later (a refresh that the window rule would call early), and then sending a refresh fifteen ticks after that, which must now be early. A scoreboard holds the predicted tick and cause of every failure and compares them when the reset output falls.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
  typedef enum logic [1:0] {
    WD_RUN   = 2'd0,
    WD_PULSE = 2'd1,
    WD_SAFE  = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdg_frame_capture.sv
`timescale 1ns/1ps
// Holds the last written refresh bit and mode field of an SPI frame and
// resolves them into a single refresh pulse when chip select rises.
module wdg_frame_capture #(
  parameter int MODE_W = 3,
  parameter logic [2**MODE_W-1:0] ACCEPT_MASK = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              ref_bit,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              cs_n,
  output logic              refresh_o
);
  logic              cs_q, cs_d;
  logic              pend_vld, pend_vld_d;
  logic              pend_bit, pend_bit_d;
  logic [MODE_W-1:0] pend_mode, pend_mode_d;
  logic              stored_bit, stored_bit_d;
  logic              commit, mode_ok, take, cap_en;

  always_comb begin
    commit       = !cs_q && cs_n;
    mode_ok      = ACCEPT_MASK[pend_mode];
    take         = commit && pend_vld && mode_ok;
    refresh_o    = take && (pend_bit != stored_bit);
    cap_en       = wr_stb && !cs_n;
    cs_d         = cs_n;
    pend_vld_d   = pend_vld;
    pend_bit_d   = pend_bit;
    pend_mode_d  = pend_mode;
    if (cap_en) begin
      pend_vld_d  = 1'b1;
      pend_bit_d  = ref_bit;
      pend_mode_d = mode_sel;
    end else if (commit) begin
      pend_vld_d  = 1'b0;
    end
    stored_bit_d = take ? pend_bit : stored_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= 1'b1;
      pend_vld   <= 1'b0;
      pend_bit   <= 1'b0;
      pend_mode  <= '0;
      stored_bit <= 1'b0;
    end else begin
      cs_q       <= cs_d;
      pend_vld   <= pend_vld_d;
      pend_bit   <= pend_bit_d;
      pend_mode  <= pend_mode_d;
      stored_bit <= stored_bit_d;
    end
  end

  assert_refresh_at_cs_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |-> cs_n);
endmodule

// File: rtl/wdg_timer.sv
`timescale 1ns/1ps
// Period counter with time-out and window judgement and the active setting.
module wdg_timer #(
  parameter int BASE_MS  = 16,
  parameter int CODE_W   = 3,
  parameter int CODE_MAX = 6,
  parameter int DEF_CODE = 4,
  parameter int CNT_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              refresh_i,
  input  logic              hold_i,
  input  logic              cfg_window_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  output logic              fail_timeout_o,
  output logic              fail_early_o
);
  localparam logic [CODE_W-1:0] CODE_LIM = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] CODE_DEF = CODE_W'(DEF_CODE);

  function automatic logic [CNT_W-1:0] period_of(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] cc;
    cc = (c > CODE_LIM) ? CODE_LIM : c;
    return CNT_W'(BASE_MS) << cc;
  endfunction

  logic [CNT_W-1:0]  cnt, cnt_d, per, half;
  logic              act_win, act_win_d;
  logic [CODE_W-1:0] act_code, act_code_d;
  logic              closed, good_ref, cnt_en, cfg_en;

  always_comb begin
    per            = period_of(act_code);
    half           = per >> 1;
    closed         = act_win && (cnt < half);
    fail_early_o   = !hold_i && refresh_i && closed;
    good_ref       = !hold_i && refresh_i && !closed;
    fail_timeout_o = !hold_i && !refresh_i && ms_tick && (cnt == per - 1'b1);
    cnt_en         = hold_i || refresh_i || ms_tick;
    cfg_en         = hold_i || good_ref;
    cnt_d          = cnt;
    act_win_d      = act_win;
    act_code_d     = act_code;
    if (hold_i) begin
      cnt_d      = '0;
      act_win_d  = 1'b0;
      act_code_d = CODE_DEF;
    end else if (good_ref) begin
      cnt_d      = '0;
      act_win_d  = cfg_window_i;
      act_code_d = cfg_code_i;
    end else if (fail_early_o || fail_timeout_o) begin
      cnt_d      = '0;
    end else if (ms_tick) begin
      cnt_d      = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      act_win  <= 1'b0;
      act_code <= CODE_DEF;
    end else begin
      if (cnt_en) cnt <= cnt_d;
      if (cfg_en) begin
        act_win  <= act_win_d;
        act_code <= act_code_d;
      end
    end
  end

  assert_cnt_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < per);
  assert_timeout_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_timeout_o |-> ms_tick);
  assert_early_needs_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_early_o |-> (refresh_i && act_win));
  assert_hold_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt == '0));
endmodule

// File: rtl/wdg_fail_ctrl.sv
`timescale 1ns/1ps
// Turns failure pulses into the reset output, the policy request and status.
module wdg_fail_ctrl
  import wdg_pkg::*;
#(
  parameter int RST_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic fail_timeout_i,
  input  logic fail_early_i,
  input  logic policy_safe_i,
  output logic hold_o,
  output logic wd_reset_n_o,
  output logic req_restart_o,
  output logic req_failsafe_o,
  output logic stat_timeout_o,
  output logic stat_early_o
);
  localparam int PCNT_W = $clog2(RST_TICKS + 1);
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(RST_TICKS - 1);

  wd_state_e         state, state_d;
  logic [PCNT_W-1:0] pcnt, pcnt_d;
  logic              st_to_d, st_ea_d, any_fail, pcnt_en;

  always_comb begin
    any_fail = fail_timeout_i || fail_early_i;
    state_d  = state;
    pcnt_d   = pcnt;
    pcnt_en  = 1'b0;
    unique case (state)
      WD_RUN: begin
        if (any_fail) begin
          state_d = policy_safe_i ? WD_SAFE : WD_PULSE;
          pcnt_d  = '0;
          pcnt_en = 1'b1;
        end
      end
      WD_PULSE: begin
        if (ms_tick) begin
          pcnt_en = 1'b1;
          if (pcnt == PCNT_LAST) begin
            state_d = WD_RUN;
            pcnt_d  = '0;
          end else begin
            pcnt_d  = pcnt + 1'b1;
          end
        end
      end
      default: state_d = WD_SAFE;
    endcase
    st_to_d        = stat_timeout_o || (state == WD_RUN && fail_timeout_i);
    st_ea_d        = stat_early_o   || (state == WD_RUN && fail_early_i);
    hold_o         = (state != WD_RUN);
    wd_reset_n_o   = (state == WD_RUN);
    req_restart_o  = (state == WD_PULSE);
    req_failsafe_o = (state == WD_SAFE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= WD_RUN;
      pcnt           <= '0;
      stat_timeout_o <= 1'b0;
      stat_early_o   <= 1'b0;
    end else begin
      state          <= state_d;
      if (pcnt_en) pcnt <= pcnt_d;
      stat_timeout_o <= st_to_d;
      stat_early_o   <= st_ea_d;
    end
  end

  assert_reset_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_reset_n_o && (fail_timeout_i || fail_early_i)) |=> !wd_reset_n_o);
  assert_single_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_restart_o && req_failsafe_o));
  assert_failsafe_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_failsafe_o |=> (req_failsafe_o && !wd_reset_n_o));
  assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_timeout_o |=> stat_timeout_o);
  assert_early_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_early_o |=> stat_early_o);
endmodule

// File: rtl/wdg_supervisor.sv
`timescale 1ns/1ps
module wdg_supervisor #(
  parameter int BASE_MS   = 16,
  parameter int CODE_W    = 3,
  parameter int CODE_MAX  = 6,
  parameter int DEF_CODE  = 4,
  parameter int RST_TICKS = 8,
  parameter int MODE_W    = 3,
  parameter logic [2**MODE_W-1:0] ACCEPT_MASK = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              spi_wr_stb,
  input  logic              spi_refresh_bit,
  input  logic [MODE_W-1:0] spi_mode_sel,
  input  logic              spi_cs_n,
  input  logic [CODE_W-1:0] cfg_period_code,
  input  logic              cfg_window_mode,
  input  logic              cfg_fail_safe,
  output logic              wd_reset_n,
  output logic              req_restart,
  output logic              req_failsafe,
  output logic              stat_timeout,
  output logic              stat_early
);
  localparam int CNT_W = $clog2(BASE_MS << CODE_MAX) + 1;

  logic refresh, hold, fail_to, fail_ea;

  wdg_frame_capture #(
    .MODE_W(MODE_W), .ACCEPT_MASK(ACCEPT_MASK)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .wr_stb(spi_wr_stb), .ref_bit(spi_refresh_bit),
    .mode_sel(spi_mode_sel), .cs_n(spi_cs_n), .refresh_o(refresh)
  );

  wdg_timer #(
    .BASE_MS(BASE_MS), .CODE_W(CODE_W), .CODE_MAX(CODE_MAX),
    .DEF_CODE(DEF_CODE), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .refresh_i(refresh),
    .hold_i(hold), .cfg_window_i(cfg_window_mode), .cfg_code_i(cfg_period_code),
    .fail_timeout_o(fail_to), .fail_early_o(fail_ea)
  );

  wdg_fail_ctrl #(
    .RST_TICKS(RST_TICKS)
  ) u_fail (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .fail_timeout_i(fail_to),
    .fail_early_i(fail_ea), .policy_safe_i(cfg_fail_safe), .hold_o(hold),
    .wd_reset_n_o(wd_reset_n), .req_restart_o(req_restart),
    .req_failsafe_o(req_failsafe), .stat_timeout_o(stat_timeout),
    .stat_early_o(stat_early)
  );
endmodule

// File: tb/wdg_supervisor_test.sv
`timescale 1ns/1ps
module wdg_supervisor_test;
  localparam int KIND_TO = 1;
  localparam int KIND_EA = 2;
  localparam int RSTT    = 8;

  logic clk, rst_n, ms_tick, spi_wr_stb, spi_refresh_bit, spi_cs_n;
  logic [2:0] spi_mode_sel, cfg_period_code;
  logic cfg_window_mode, cfg_fail_safe;
  logic wd_reset_n, req_restart, req_failsafe, stat_timeout, stat_early;

  wdg_supervisor uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .spi_wr_stb(spi_wr_stb),
    .spi_refresh_bit(spi_refresh_bit), .spi_mode_sel(spi_mode_sel),
    .spi_cs_n(spi_cs_n), .cfg_period_code(cfg_period_code),
    .cfg_window_mode(cfg_window_mode), .cfg_fail_safe(cfg_fail_safe),
    .wd_reset_n(wd_reset_n), .req_restart(req_restart),
    .req_failsafe(req_failsafe), .stat_timeout(stat_timeout),
    .stat_early(stat_early)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct { int kind; int tick; string tag; } exp_t;
  exp_t exp_q[$];
  int   checks = 0, errors = 0;
  int   tick_cnt = 0, ref_t = 0;
  logic cur_bit = 1'b0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic expect_fail(input int kind, input int at, input string tag);
    exp_t e;
    e.kind = kind; e.tick = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: pops the predicted failure whenever the reset output falls
  initial begin
    forever begin
      @(negedge wd_reset_n);
      #1;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5/R6 unexpected failure", tick_cnt, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(tick_cnt == e.tick, {e.tag, " failure tick"}, tick_cnt, e.tick);
        if (e.kind == KIND_TO)
          chk(stat_timeout == 1'b1, {e.tag, " R10 timeout status"}, int'(stat_timeout), 1);
        else
          chk(stat_early == 1'b1, {e.tag, " R10 early status"}, int'(stat_early), 1);
      end
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1'b1; tick_cnt++;
      @(negedge clk); ms_tick = 1'b0;
    end
  endtask

  task automatic frame_open(input logic b, input logic [2:0] m);
    @(negedge clk); spi_cs_n = 1'b0;
    @(negedge clk); spi_wr_stb = 1'b1; spi_refresh_bit = b; spi_mode_sel = m;
    @(negedge clk); spi_wr_stb = 1'b0;
  endtask

  task automatic frame_close();
    @(negedge clk); spi_cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic frame(input logic b, input logic [2:0] m);
    frame_open(b, m);
    frame_close();
  endtask

  task automatic toggle();
    cur_bit = ~cur_bit;
    frame(cur_bit, 3'd0);
    ref_t = tick_cnt;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ms_tick = 1'b0; spi_wr_stb = 1'b0; spi_cs_n = 1'b1;
    spi_refresh_bit = 1'b0; spi_mode_sel = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_bit = 1'b0;
    ref_t = tick_cnt;
  endtask

  task automatic wd_level(input logic e, input string tag);
    chk(wd_reset_n == e, tag, int'(wd_reset_n), int'(e));
  endtask

  initial begin
    cfg_period_code = 3'd4; cfg_window_mode = 1'b0; cfg_fail_safe = 1'b0;
    do_reset();

    // R11 reset state
    wd_level(1'b1, "R11 reset output");
    chk(req_restart == 1'b0, "R11 restart request", int'(req_restart), 0);
    chk(req_failsafe == 1'b0, "R11 failsafe request", int'(req_failsafe), 0);
    chk(stat_timeout == 1'b0, "R11 timeout status", int'(stat_timeout), 0);
    chk(stat_early == 1'b0, "R11 early status", int'(stat_early), 0);

    // R7 default 256, R5 expiry, R8 restart pulse
    expect_fail(KIND_TO, ref_t + 256, "R7 default period");
    ticks(255); wd_level(1'b1, "R5 before expiry");
    ticks(1);   wd_level(1'b0, "R8 reset low on expiry");
    chk(req_restart == 1'b1, "R8 restart request", int'(req_restart), 1);
    ticks(RSTT - 1); wd_level(1'b0, "R8 pulse still low");
    ticks(1);   wd_level(1'b1, "R8 pulse ended");
    chk(req_restart == 1'b0, "R8 restart request cleared", int'(req_restart), 0);
    chk(stat_timeout == 1'b1, "R10 timeout kept", int'(stat_timeout), 1);

    // R8 fallback with window settings waiting on the inputs
    cfg_window_mode = 1'b1; cfg_period_code = 3'd1;
    ticks(10); toggle();           // judged as time-out mode: accepted
    ticks(15);
    expect_fail(KIND_EA, tick_cnt, "R6 closed window");
    toggle();
    wd_level(1'b0, "R6 early refresh resets");
    ticks(RSTT);
    wd_level(1'b1, "R8 second pulse ended");

    // R6 open window boundary
    ticks(5); toggle();            // loads window, 32 ticks
    ticks(16); toggle();
    wd_level(1'b1, "R6 refresh at half period accepted");
    ticks(31); toggle();
    wd_level(1'b1, "R6 refresh at last tick accepted");
    expect_fail(KIND_TO, ref_t + 32, "R6 window expiry");
    ticks(31); wd_level(1'b1, "R6 before window expiry");
    ticks(1);  wd_level(1'b0, "R6 window expiry");
    ticks(RSTT);

    // R1 toggle rule
    cfg_window_mode = 1'b0; cfg_period_code = 3'd4;
    do_reset();
    ticks(100); toggle();
    ticks(100); frame(cur_bit, 3'd1);   // same bit: no refresh
    expect_fail(KIND_TO, ref_t + 256, "R1 repeated bit");
    ticks(155); wd_level(1'b1, "R1 before expiry");
    ticks(1);   wd_level(1'b0, "R1 repeated bit did not refresh");

    // R3 mode filter
    do_reset();
    ticks(50); frame(1'b1, 3'd5);      // rejected
    ticks(50); cur_bit = 1'b1; frame(1'b1, 3'd2); ref_t = tick_cnt;
    expect_fail(KIND_TO, ref_t + 256, "R3 accepted after rejected");
    ticks(100); frame(1'b0, 3'd7);     // rejected toggle
    ticks(155); wd_level(1'b1, "R3 rejected frame ignored");
    ticks(1);   wd_level(1'b0, "R3 deadline kept");

    // R2 commit on chip-select rise
    do_reset();
    ticks(250); frame_open(1'b1, 3'd0);
    ticks(5); wd_level(1'b1, "R2 before expiry");
    expect_fail(KIND_TO, ref_t + 256, "R2 open frame");
    ticks(1); wd_level(1'b0, "R2 no effect while selected");
    frame_close();

    // R4 period codes
    do_reset();
    cfg_period_code = 3'd0;
    ticks(3); toggle();
    expect_fail(KIND_TO, ref_t + 16, "R4 code 0");
    ticks(15); wd_level(1'b1, "R4 code 0 before");
    ticks(1);  wd_level(1'b0, "R4 code 0 expiry");
    ticks(RSTT);
    cfg_period_code = 3'd7;
    ticks(1); toggle();
    expect_fail(KIND_TO, ref_t + 1024, "R4 code 7 clamp");
    ticks(1023); wd_level(1'b1, "R4 code 7 before");
    ticks(1);    wd_level(1'b0, "R4 code 7 expiry");
    ticks(RSTT);
    cfg_period_code = 3'd2;
    toggle();
    expect_fail(KIND_TO, ref_t + 64, "R4 code 2");
    ticks(63); wd_level(1'b1, "R4 code 2 before");
    ticks(1);  wd_level(1'b0, "R4 code 2 expiry");

    // R9 fail-safe policy
    do_reset();
    cfg_fail_safe = 1'b1; cfg_period_code = 3'd0;
    toggle();
    expect_fail(KIND_TO, ref_t + 16, "R9 failsafe");
    ticks(16);
    wd_level(1'b0, "R9 reset low");
    chk(req_failsafe == 1'b1, "R9 failsafe request", int'(req_failsafe), 1);
    chk(req_restart == 1'b0, "R9 no restart request", int'(req_restart), 0);
    ticks(40); toggle();
    wd_level(1'b0, "R9 still held after refresh");
    chk(req_failsafe == 1'b1, "R9 request held", int'(req_failsafe), 1);
    do_reset();
    wd_level(1'b1, "R11 released by block reset");
    chk(req_failsafe == 1'b0, "R11 failsafe cleared", int'(req_failsafe), 0);
    chk(stat_timeout == 1'b0, "R11 status cleared", int'(stat_timeout), 0);

    chk(exp_q.size() == 0, "R5 all predicted failures seen", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule